// File: doc/BRIEF.md
# Bus Wake-Up Detector and Chip-Select Filter

This block sits between the raw inputs of a bus transceiver and its mode controller. While the controller reports the sleep state, the block watches the received bus level for a remote wake-up. A remote wake-up is an edge of the configured polarity, followed by the new level held for a minimum number of clock cycles. The block also watches a dedicated local wake pin for a falling edge. Either event raises a single-cycle wake request.

Independently of the sleep state, the block filters the chip-select input. The filtered level follows the raw input only after the raw input has held a new value for a set number of cycles. A short glitch therefore cannot wake the device or send it to sleep.

All three raw inputs pass through a two-stage synchronizer first. The dwell and filter durations are parameters counted in clock cycles. One parameter selects wake-up on a falling bus edge or on a rising bus edge. Another parameter removes the local wake pin.

Top module: `bus_wake_filter`

## Requirements
- R1: During reset and on the first cycle after it, `wake_req_o` is 0 and `csel_filt_o` is 0.
- R2: With `RISE_WAKE`=0, the following is a bus wake: a high-to-low change of `bus_lvl_i` while `sleep_i` is 1, with the low level present on `DWELL_CYC` consecutive clock edges. It raises `wake_req_o` right after the edge that is `DWELL_CYC`+2 edges after the change was driven.
- R3: With `RISE_WAKE`=1, the same rule applies to a low-to-high change followed by a high dwell, with the same latency.
- R4: If the bus level returns before the dwell completes, nothing is signalled and the count is discarded. A dwell shorter than `DWELL_CYC` samples, including one of `DWELL_CYC`-1, gives no wake. A later dwell needs a fresh edge.
- R5: An edge of the opposite polarity never wakes. A level held far beyond the dwell gives exactly one request.
- R6: Wake detection is armed only while `sleep_i` is 1. An edge seen before arming gives no wake. Dropping `sleep_i` during a dwell cancels it.
- R7: With `HAS_WAKE_PIN`=1, a falling edge of `wake_pin_i` while `sleep_i` is 1 raises `wake_req_o` after the third clock edge. With `sleep_i` at 0 it has no effect. With `HAS_WAKE_PIN`=0 the pin is ignored.
- R8: `csel_filt_o` takes the value of `csel_raw_i` after the raw input has differed from it on `CSEL_CYC` consecutive edges. The change is visible after edge `CSEL_CYC`+2. Shorter glitches leave `csel_filt_o` unchanged.
- R9: Each wake source raises its request for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | High while the mode controller is in its sleep state; arms wake detection |
| bus_lvl_i | input | 1 | Raw received bus level (asynchronous) |
| wake_pin_i | input | 1 | Raw local wake pin, active on a falling edge (asynchronous) |
| csel_raw_i | input | 1 | Raw chip-select input (asynchronous) |
| wake_req_o | output | 1 | Single-cycle wake request |
| csel_filt_o | output | 1 | Debounced chip-select level |

## Verification
The bench builds two copies of the block, both with `DWELL_CYC`=12 and `CSEL_CYC`=6 instead of the microsecond-scale defaults.

- The first copy wakes on a falling bus edge and has the wake pin.
- The second copy wakes on a rising bus edge and has no wake pin, so one run covers both polarities and the pin's absence.

Such short counts put the exact thresholds within a few cycles: a dwell of 11 against 12 samples, and a glitch of 5 against 6. Random pulse lengths therefore land on both sides of each threshold many times.

// File: rtl/bus_wake_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bus wake-up and chip-select filter block.
// Assumes: nothing beyond IEEE 1800-2017.
package bus_wake_pkg;

    // Synchronizer depth for all asynchronous inputs
    localparam int unsigned SYNC_DEPTH = 2;

    // Bit positions inside the synchronized input vector
    localparam int unsigned IN_BUS   = 0;
    localparam int unsigned IN_PIN   = 1;
    localparam int unsigned IN_CSEL  = 2;
    localparam int unsigned IN_COUNT = 3;

    // Dwell tracker state
    typedef enum logic {
        DW_IDLE = 1'b0,
        DW_HOLD = 1'b1
    } dwell_state_t;

    // Width of a counter that holds values 0 .. lim-1
    function automatic int unsigned cnt_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/wk_sync.sv
`timescale 1ns/1ps
// Multi-bit flop chain that brings asynchronous levels into the clock domain.
// Assumes: each bit is an independent level; no bus coherency is implied.
module wk_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     DEPTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the value along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[DEPTH-1];

endmodule

// File: rtl/wk_bus_dwell.sv
`timescale 1ns/1ps
// Bus wake qualifier: an edge into the active level, followed by that level
// on DWELL_CYC consecutive samples (the edge sample included), gives one
// pulse on wake_o. Leaving the active level or disarming cancels the count.
// Assumes: lvl_i is already synchronized; its reset value is IDLE_RST.
module wk_bus_dwell
    import bus_wake_pkg::*;
#(
    parameter bit          RISE      = 1'b0,
    parameter int unsigned DWELL_CYC = 2500,
    parameter bit          IDLE_RST  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic lvl_i,
    output logic wake_o
);

    localparam logic           ACT  = RISE ? 1'b1 : 1'b0;
    localparam int unsigned    CW   = cnt_bits(DWELL_CYC);
    localparam logic [CW-1:0]  LAST = CW'(DWELL_CYC - 1);
    localparam logic [CW-1:0]  ONE  = CW'(1);

    dwell_state_t   st_q;
    logic [CW-1:0]  cnt_q;
    logic           prev_q;
    logic           wake_q;
    logic           edge_seen;

    // Edge into the active level since the previous sample
    assign edge_seen = (lvl_i == ACT) && (prev_q != ACT);

    // Previous-sample register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_RST;
        else        prev_q <= lvl_i;
    end

    // Dwell tracker and wake pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DW_IDLE;
            cnt_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            case (st_q)
                DW_IDLE: begin
                    cnt_q <= '0;
                    if (arm_i && edge_seen) begin
                        if (LAST == '0) begin
                            wake_q <= 1'b1;
                        end else begin
                            st_q  <= DW_HOLD;
                            cnt_q <= ONE;
                        end
                    end
                end
                DW_HOLD: begin
                    if (!arm_i || (lvl_i != ACT)) begin
                        st_q  <= DW_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        st_q   <= DW_IDLE;
                        cnt_q  <= '0;
                        wake_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: begin
                    st_q  <= DW_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign wake_o = wake_q;

    // R9: a bus wake is a single-cycle pulse
    p_bus_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);

    // R6: a bus wake is decided only while armed
    p_bus_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(arm_i));

    // R4: the wake is decided on a sample at the active level
    p_bus_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> ($past(lvl_i) == ACT));

    // R2: the dwell counter stays inside its range
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/wk_pin_edge.sv
`timescale 1ns/1ps
// Local wake pin detector: a falling edge of the synchronized pin while
// armed gives one pulse on fire_o.
// Assumes: pin_i is synchronized and idles high (pulled up).
module wk_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic pin_i,
    output logic fire_o
);

    logic prev_q;
    logic fire_q;

    // Previous pin sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_i;
    end

    // Falling-edge pulse, gated by arming
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= arm_i && prev_q && !pin_i;
    end

    assign fire_o = fire_q;

    // R9: a pin wake is a single-cycle pulse
    p_pin_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);

endmodule

// File: rtl/wk_hold_filter.sv
`timescale 1ns/1ps
// Level debouncer: the output takes a new input value only after the input
// has differed from the output on HOLD_CYC consecutive samples.
// Assumes: in_i is synchronized; HOLD_CYC is at least 1.
module wk_hold_filter
    import bus_wake_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 1250,
    parameter bit          RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic filt_o
);

    localparam int unsigned   CW   = cnt_bits(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Count samples that disagree with the output; commit on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= RST_VAL;
        end else if (in_i == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            filt_q <= in_i;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign filt_o = filt_q;

    // R8: the output only ever moves to the value the input was holding
    p_filt_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> (filt_q == $past(in_i)));

    // R8: an agreeing input keeps the output still
    p_filt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i == filt_q) |=> $stable(filt_q));

    // R8: the filter counter stays inside its range
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/bus_wake_filter.sv
`timescale 1ns/1ps
// Top of the wake-up and chip-select filter block. It synchronizes the raw
// inputs, qualifies bus and pin wake-ups while sleep_i is high, and
// debounces chip-select.
// Assumes: sleep_i comes from the same clock domain; durations are in cycles.
module bus_wake_filter
    import bus_wake_pkg::*;
#(
    parameter bit          RISE_WAKE    = 1'b0,
    parameter bit          HAS_WAKE_PIN = 1'b1,
    parameter int unsigned DWELL_CYC    = 2500,
    parameter int unsigned CSEL_CYC     = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic bus_lvl_i,
    input  logic wake_pin_i,
    input  logic csel_raw_i,
    output logic wake_req_o,
    output logic csel_filt_o
);

    localparam logic [IN_COUNT-1:0] SYNC_RST = IN_COUNT'(
        (1 << IN_BUS) | (1 << IN_PIN));

    logic [IN_COUNT-1:0] raw_vec;
    logic [IN_COUNT-1:0] syn_vec;
    logic                bus_fire;
    logic                pin_fire;

    assign raw_vec[IN_BUS]  = bus_lvl_i;
    assign raw_vec[IN_PIN]  = wake_pin_i;
    assign raw_vec[IN_CSEL] = csel_raw_i;

    wk_sync #(
        .WIDTH   (IN_COUNT),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (syn_vec)
    );

    wk_bus_dwell #(
        .RISE      (RISE_WAKE),
        .DWELL_CYC (DWELL_CYC),
        .IDLE_RST  (1'b1)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (sleep_i),
        .lvl_i  (syn_vec[IN_BUS]),
        .wake_o (bus_fire)
    );

    generate
        if (HAS_WAKE_PIN) begin : g_pin
            wk_pin_edge u_pin (
                .clk    (clk),
                .rst_n  (rst_n),
                .arm_i  (sleep_i),
                .pin_i  (syn_vec[IN_PIN]),
                .fire_o (pin_fire)
            );
        end else begin : g_no_pin
            assign pin_fire = 1'b0;
        end
    endgenerate

    wk_hold_filter #(
        .HOLD_CYC (CSEL_CYC),
        .RST_VAL  (1'b0)
    ) u_csel (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (syn_vec[IN_CSEL]),
        .filt_o (csel_filt_o)
    );

    assign wake_req_o = bus_fire | pin_fire;

    // R6: no wake request appears unless sleep was reported on the deciding edge
    p_wake_in_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> $past(sleep_i));

endmodule

// File: tb/sim_bus_wake_filter.sv
`timescale 1ns/1ps
module sim_bus_wake_filter;

    localparam int D = 12;
    localparam int C = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0;
    logic bus0 = 1'b1;
    logic bus1 = 1'b0;
    logic pin = 1'b1;
    logic cs = 1'b0;
    logic wk0, wk1, csf0, csf1;

    always #4 clk = ~clk;

    bus_wake_filter #(.RISE_WAKE(1'b0), .HAS_WAKE_PIN(1'b1), .DWELL_CYC(D), .CSEL_CYC(C)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .bus_lvl_i(bus0),
        .wake_pin_i(pin), .csel_raw_i(cs), .wake_req_o(wk0), .csel_filt_o(csf0));

    bus_wake_filter #(.RISE_WAKE(1'b1), .HAS_WAKE_PIN(1'b0), .DWELL_CYC(D), .CSEL_CYC(C)) u1 (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .bus_lvl_i(bus1),
        .wake_pin_i(pin), .csel_raw_i(1'b0), .wake_req_o(wk1), .csel_filt_o(csf1));

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int w0_n = 0, w1_n = 0, w0_at = 0, w1_at = 0, dbl = 0, cs_tog = 0;
    bit w0_prev = 0, w1_prev = 0, csf_prev = 0, done = 0;

    // Posedge counter
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (wk0 === 1'b1) begin w0_n++; w0_at = cyc; if (w0_prev) dbl++; end
        if (wk1 === 1'b1) begin w1_n++; w1_at = cyc; if (w1_prev) dbl++; end
        w0_prev = (wk0 === 1'b1);
        w1_prev = (wk1 === 1'b1);
        if ((csf0 === 1'b1) != csf_prev) cs_tog++;
        csf_prev = (csf0 === 1'b1);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected number of bus wakes for an active dwell of len samples
    function automatic int exp_wakes(input int len);
        return (len >= D) ? 1 : 0;
    endfunction

    // Expected filter toggles for a chip-select glitch of len samples
    function automatic int exp_toggles(input int len);
        return (len >= C) ? 2 : 0;
    endfunction

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int b0, b1, p, t0, len;
        void'($urandom(32'd5150));
        step(3);
        chk(wk0 == 1'b0 && csf0 == 1'b0, "R1 reset outputs u0", {wk0, csf0}, 0);
        chk(wk1 == 1'b0, "R1 reset wake u1", wk1, 0);
        rst_n = 1'b1;
        step(1);
        chk(wk0 == 1'b0 && csf0 == 1'b0, "R1 first cycle after reset", {wk0, csf0}, 0);
        step(4);
        w0_n = 0; w1_n = 0; dbl = 0; cs_tog = 0;

        // R6: not armed, long low dwell and pin edge do nothing
        bus0 = 1'b0; step(2 * D); bus0 = 1'b1; step(6);
        pin = 1'b0; step(3); pin = 1'b1; step(6);
        chk(w0_n == 0, "R6 no wake while awake", w0_n, 0);
        chk(w0_n == 0, "R7 pin ignored while awake", w0_n, 0);

        // R6: edge seen before arming is not a wake
        bus0 = 1'b0; step(5); sleep = 1'b1; step(D + 6);
        bus0 = 1'b1; step(6);
        chk(w0_n == 0, "R6 edge before arming", w0_n, 0);

        // R2: exact dwell, latency check
        b0 = w0_n;
        bus0 = 1'b0; p = cyc; step(D); bus0 = 1'b1; step(8);
        chk(w0_n - b0 == 1, "R2 exact dwell wakes", w0_n - b0, 1);
        chk(w0_at - p == D + 2, "R2 wake latency", w0_at - p, D + 2);

        // R4: one sample short
        b0 = w0_n;
        bus0 = 1'b0; step(D - 1); bus0 = 1'b1; step(8);
        chk(w0_n == b0, "R4 dwell one short", w0_n - b0, 0);

        // R4: interrupted dwell needs a new edge
        b0 = w0_n;
        bus0 = 1'b0; step(D - 2); bus0 = 1'b1; step(1); bus0 = 1'b0; step(D - 2);
        bus0 = 1'b1; step(8);
        chk(w0_n == b0, "R4 interrupted dwell", w0_n - b0, 0);

        // R5: long hold gives one request, return edge gives none
        b0 = w0_n;
        bus0 = 1'b0; step(3 * D); bus0 = 1'b1; step(2 * D);
        chk(w0_n - b0 == 1, "R5 long hold single request", w0_n - b0, 1);

        // R6: dropping sleep mid-dwell cancels
        b0 = w0_n;
        bus0 = 1'b0; step(D / 2); sleep = 1'b0; step(2); sleep = 1'b1; step(D + 6);
        bus0 = 1'b1; step(8);
        chk(w0_n == b0, "R6 disarm cancels dwell", w0_n - b0, 0);

        // R7: pin falling edge in sleep, latency 3; absent on u1
        b0 = w0_n; b1 = w1_n;
        pin = 1'b0; p = cyc; step(2); pin = 1'b1; step(6);
        chk(w0_n - b0 == 1, "R7 pin wake", w0_n - b0, 1);
        chk(w0_at - p == 3, "R7 pin latency", w0_at - p, 3);
        chk(w1_n == b1, "R7 pin absent variant", w1_n - b1, 0);

        // R3: rising variant
        b1 = w1_n;
        bus1 = 1'b1; p = cyc; step(D); bus1 = 1'b0; step(8);
        chk(w1_n - b1 == 1, "R3 rising dwell wakes", w1_n - b1, 1);
        chk(w1_at - p == D + 2, "R3 rising latency", w1_at - p, D + 2);
        b1 = w1_n;
        bus1 = 1'b1; step(D - 1); bus1 = 1'b0; step(8);
        chk(w1_n == b1, "R3 rising one short", w1_n - b1, 0);
        chk(w0_n == b0 + 1, "R5 u0 quiet during u1 test", w0_n - b0, 1);

        // R8: chip-select latency
        cs = 1'b1; step(C + 1);
        chk(csf0 == 1'b0, "R8 filter before threshold", csf0, 0);
        step(1);
        chk(csf0 == 1'b1, "R8 filter at threshold", csf0, 1);
        cs = 1'b0; step(C + 4);
        chk(csf0 == 1'b0, "R8 filter returns low", csf0, 0);
        t0 = cs_tog;
        cs = 1'b1; step(C - 1); cs = 1'b0; step(C + 4);
        chk(cs_tog == t0, "R8 glitch one short", cs_tog - t0, 0);

        // Random mix, both sides of each threshold
        for (int k = 0; k < 40; k++) begin
            len = 1 + $urandom_range(2 * D - 1, 0);
            b0 = w0_n;
            bus0 = 1'b0; step(len); bus0 = 1'b1; step(D + 6);
            chk(w0_n - b0 == exp_wakes(len), "R2 random falling dwell", w0_n - b0, exp_wakes(len));
            len = 1 + $urandom_range(2 * D - 1, 0);
            b1 = w1_n;
            bus1 = 1'b1; step(len); bus1 = 1'b0; step(D + 6);
            chk(w1_n - b1 == exp_wakes(len), "R3 random rising dwell", w1_n - b1, exp_wakes(len));
            len = 1 + $urandom_range(2 * C - 1, 0);
            t0 = cs_tog;
            cs = 1'b1; step(len); cs = 1'b0; step(C + 5);
            chk(cs_tog - t0 == exp_toggles(len), "R8 random glitch", cs_tog - t0, exp_toggles(len));
        end

        chk(dbl == 0, "R9 single-cycle requests", dbl, 0);
        done = 1;
        summary();
        $finish;
    end

endmodule